// File: doc/BRIEF.md
# Switched-Tap Generalized Accumulator

This block is the inner code of a repeat-accumulate style encoder. It takes a frame of M combiner bits, one per accepted transfer, and returns M parity bits in the same order. Each parity bit is the running XOR of the combiner stream, as in a plain accumulator. An extra feedback tap can also fold in the parity bit produced `lag + 1` positions earlier. That tap is idle for the first `lag + 1` outputs of a frame. After that it fires on one output in every `gap + 1`, starting with the first eligible one. Spacing the tapped outputs like this separates the weight-3 parity columns of the code.

The frame length, the tap lag and the gap are run-time configuration inputs. They are held stable while a frame is in flight. The lag is bounded by the synthesis parameter `LAG_MAX`. A configuration whose lag reaches the end of the frame is reported as invalid, and while it is reported the block accepts no input. Choosing the lag from the code's rate and degree profile is done offline.

Input and output use valid/ready handshakes. A registered output stage gives one cycle of latency per bit. The output carries an end-of-frame flag on the M-th parity bit. The parity history and the gap phase are cleared at every frame boundary.

Top module: `switched_tap_accum`

## Requirements
- R1: The first parity bit of every frame equals the first input bit of that frame.
- R2: For output positions i from 2 up to lag+1, the parity bit is the previous parity bit XOR the current input bit.
- R3: For i >= lag+2, the parity bit also XORs in the parity bit from position i-lag-1, but only when (i-lag-2) is a multiple of gap+1. At every other position the R2 rule applies.
- R4: With gap = 0 the tap fires on every position from lag+2 to M.
- R5: Parity history and gap phase restart at each frame boundary, so a frame's outputs depend only on that frame's inputs.
- R6: A bit accepted at a clock edge appears on the output right after that same edge. `out_last_o` is 1 exactly on the M-th parity bit of a frame.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, the output bit and last flag are held and `in_ready_o` is 0. Input presented during the hold is not absorbed.
- R8: When lag+1 >= M, `cfg_bad_o` is 1 and `in_ready_o` is 0. No bit is taken, so a later valid frame is unaffected.
- R9: With M = 7, lag = 2, gap = 1 and input 1,0,0,1,0,1,0 (first bit first), the output is seven ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_len_i | input | 11 | Frame length M |
| cfg_lag_i | input | 6 | Tap lag; the tap reads parity lag+1 positions back |
| cfg_gap_i | input | 4 | Gap s; the tap fires once every s+1 positions |
| cfg_bad_o | output | 1 | Configuration invalid (lag+1 >= M) |
| in_valid_i | input | 1 | Input bit valid |
| in_ready_o | output | 1 | Block can take an input bit |
| in_bit_i | input | 1 | Combiner bit |
| out_valid_o | output | 1 | Parity bit valid |
| out_ready_i | input | 1 | Consumer takes the parity bit |
| out_bit_o | output | 1 | Parity bit |
| out_last_o | output | 1 | Parity bit is the last of its frame |

## Verification
The assertions check these properties on every cycle:
- the output is held stable under backpressure;
- the first bit of a frame passes straight through;
- the history and phase are cleared after a last transfer;
- a tap firing is followed by a non-tap position when the gap is nonzero;
- an invalid configuration lets no new output appear.

The exact parity sequence over a whole frame, which depends on the lag and gap arithmetic across many positions, is shown only by the bench scenarios. Each scenario compares every bit against a model built from the R2/R3 equations. The same holds for the fixed vector, the gap-zero variant and the independence of back-to-back frames.

// File: rtl/stacc_pkg.sv
package stacc_pkg;
  localparam int unsigned LEN_MAX_D = 1024;
  localparam int unsigned LAG_MAX_D = 63;
  localparam int unsigned GAP_MAX_D = 15;

  typedef struct packed {
    logic first;
    logic last;
    logic tap_en;
  } stacc_ctl_t;
endpackage

// File: rtl/stacc_phase.sv
module stacc_phase
  import stacc_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned LAG_W = 6,
  parameter int unsigned GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LAG_W-1:0] lag_i,
  input  logic [GAP_W-1:0] gap_i,
  output stacc_ctl_t       ctl_o
);
  localparam int unsigned CW = LEN_W + 1;

  logic [LEN_W-1:0] cnt_q;
  logic [GAP_W-1:0] ph_q;
  logic [CW-1:0]    cnt_p1, lag_p1;
  logic             zone;

  assign cnt_p1 = {1'b0, cnt_q} + CW'(1);
  assign lag_p1 = CW'(lag_i) + CW'(1);
  // cnt_q = i-1 for current position i; tap zone starts at i = lag+2
  assign zone   = {1'b0, cnt_q} >= lag_p1;

  assign ctl_o.first  = (cnt_q == '0);
  assign ctl_o.last   = (cnt_p1 == {1'b0, len_i});
  assign ctl_o.tap_en = zone && (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else if (acc_i) begin
      if (ctl_o.last) begin
        cnt_q <= '0;
        ph_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (zone) ph_q <= (ph_q == gap_i) ? '0 : ph_q + 1'b1;
      end
    end
  end

  // R3: with a nonzero gap a firing position is followed by a silent one
  a_r3_tap_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && ctl_o.tap_en && (gap_i != '0) && !ctl_o.last |=> !ctl_o.tap_en);

  // R5: the position count restarts after the last bit of a frame
  a_r5_frame_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && ctl_o.last |=> ctl_o.first && !ctl_o.tap_en);
endmodule

// File: rtl/stacc_hist.sv
module stacc_hist #(
  parameter int unsigned LAG_MAX = 63,
  parameter int unsigned LAG_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             clr_i,
  input  logic             d_i,
  input  logic [LAG_W-1:0] lag_i,
  output logic             prev_o,
  output logic             tap_o
);
  localparam int unsigned DEPTH = LAG_MAX + 1;

  // hist_q[k] holds the parity bit k+1 positions back
  logic [DEPTH-1:0] hist_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       hist_q[g] <= 1'b0;
      else if (acc_i) begin
        if (clr_i)       hist_q[g] <= 1'b0;
        else if (g == 0) hist_q[g] <= d_i;
        else             hist_q[g] <= hist_q[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign prev_o = hist_q[0];
  assign tap_o  = hist_q[lag_i];

  // R5: nothing of a finished frame remains visible to the next one
  a_r5_hist_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && clr_i |=> !prev_o && !tap_o);
endmodule

// File: rtl/switched_tap_accum.sv
module switched_tap_accum
  import stacc_pkg::*;
#(
  parameter int unsigned LEN_MAX = LEN_MAX_D,
  parameter int unsigned LAG_MAX = LAG_MAX_D,
  parameter int unsigned GAP_MAX = GAP_MAX_D,
  localparam int unsigned LEN_W  = $clog2(LEN_MAX + 1),
  localparam int unsigned LAG_W  = $clog2(LAG_MAX + 1),
  localparam int unsigned GAP_W  = $clog2(GAP_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic [LAG_W-1:0] cfg_lag_i,
  input  logic [GAP_W-1:0] cfg_gap_i,
  output logic             cfg_bad_o,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             in_bit_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_bit_o,
  output logic             out_last_o
);
  localparam int unsigned CW = LEN_W + 1;

  stacc_ctl_t ctl;
  logic       acc, prev_bit, tap_bit, p_next;

  assign cfg_bad_o  = (CW'(cfg_lag_i) + CW'(1)) >= CW'(cfg_len_i);
  assign in_ready_o = !cfg_bad_o && (!out_valid_o || out_ready_i);
  assign acc        = in_valid_i && in_ready_o;

  stacc_phase #(.LEN_W(LEN_W), .LAG_W(LAG_W), .GAP_W(GAP_W)) i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .len_i  (cfg_len_i),
    .lag_i  (cfg_lag_i),
    .gap_i  (cfg_gap_i),
    .ctl_o  (ctl)
  );

  stacc_hist #(.LAG_MAX(LAG_MAX), .LAG_W(LAG_W)) i_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .clr_i  (ctl.last),
    .d_i    (p_next),
    .lag_i  (cfg_lag_i),
    .prev_o (prev_bit),
    .tap_o  (tap_bit)
  );

  assign p_next = in_bit_i ^ prev_bit ^ (ctl.tap_en & tap_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_bit_o   <= 1'b0;
      out_last_o  <= 1'b0;
    end else if (acc) begin
      out_valid_o <= 1'b1;
      out_bit_o   <= p_next;
      out_last_o  <= ctl.last;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  // R7: stalled output is frozen
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_bit_o) && $stable(out_last_o));

  // R1: first bit of a frame passes through unchanged
  a_r1_first_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && ctl.first |=> out_bit_o == $past(in_bit_i));

  // R6: end-of-frame flag follows the last accepted bit one cycle later
  a_r6_last_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o && (out_last_o == $past(ctl.last)));

  // R8: an invalid configuration lets no new output appear
  a_r8_bad_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bad_o && !out_valid_o |=> !out_valid_o);
endmodule

// File: tb/test_switched_tap_accum.sv
`timescale 1ns/1ps
module test_switched_tap_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] len;
  logic [5:0]  lag;
  logic [3:0]  gap;
  logic        bad, in_valid, in_ready, in_bit, out_valid, out_ready, out_bit, out_last;

  int n_chk = 0;
  int n_bad = 0;
  int rb  [1:64];
  int ex  [1:64];
  int got [1:64];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  switched_tap_accum i_switched_tap_accum (
    .clk_i(clk), .rst_ni(rst_n), .cfg_len_i(len), .cfg_lag_i(lag), .cfg_gap_i(gap),
    .cfg_bad_o(bad), .in_valid_i(in_valid), .in_ready_o(in_ready), .in_bit_i(in_bit),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_bit_o(out_bit), .out_last_o(out_last)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nextbit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[0]);
  endfunction

  task automatic fill_rand(input int m);
    for (int i = 1; i <= m; i++) rb[i] = nextbit();
  endtask

  // model from the R1..R3 equations
  task automatic model(input int m, input int psi, input int s);
    for (int i = 1; i <= m; i++) begin
      ex[i] = rb[i];
      if (i > 1) ex[i] = ex[i] ^ ex[i-1];
      if (i >= psi + 2 && ((i - psi - 2) % (s + 1)) == 0) ex[i] = ex[i] ^ ex[i-psi-1];
    end
  endtask

  // called at a negedge; bit k accepted at next posedge, seen at following negedge (R6)
  task automatic run_frame(input int m, input int psi, input int s, input int stall_at, input string tag);
    len = 11'(m); lag = 6'(psi); gap = 4'(s);
    model(m, psi, s);
    for (int k = 1; k <= m; k++) begin
      in_valid = 1'b1; in_bit = rb[k][0];
      @(negedge clk);
      got[k] = int'(out_bit);
      chk($sformatf("%s valid bit %0d", tag, k), int'(out_valid), 1);
      chk($sformatf("%s parity bit %0d", tag, k), int'(out_bit), ex[k]);
      chk($sformatf("R6 %s last bit %0d", tag, k), int'(out_last), (k == m) ? 1 : 0);
      if (k == stall_at) begin
        out_ready = 1'b0; in_bit = ~in_bit;
        repeat (3) begin
          @(negedge clk);
          chk($sformatf("R7 %s held valid", tag), int'(out_valid), 1);
          chk($sformatf("R7 %s held bit", tag), int'(out_bit), ex[k]);
          chk($sformatf("R7 %s in_ready low", tag), int'(in_ready), 0);
        end
        out_ready = 1'b1;
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk($sformatf("R6 %s drained", tag), int'(out_valid), 0);
  endtask

  task automatic t_reset();
    len = 11'd7; lag = 6'd2; gap = 4'd1;
    @(negedge clk);
    chk("R6 reset out_valid", int'(out_valid), 0);
    chk("R6 reset in_ready", int'(in_ready), 1);
    chk("R8 reset cfg_bad", int'(bad), 0);
  endtask

  task automatic t_vector();
    int pat [1:7] = '{1, 0, 0, 1, 0, 1, 0};
    for (int i = 1; i <= 7; i++) rb[i] = pat[i];
    run_frame(7, 2, 1, 0, "R9 vector");
    for (int i = 1; i <= 7; i++) chk($sformatf("R9 vector p%0d", i), got[i], 1);
    chk("R1 vector p1 equals r1", got[1], 1);
  endtask

  task automatic t_prezone();
    fill_rand(12);
    run_frame(12, 8, 2, 0, "R2 prezone");
    for (int i = 2; i <= 9; i++) chk($sformatf("R2 running xor p%0d", i), got[i], got[i-1] ^ rb[i]);
  endtask

  task automatic t_gaps();
    fill_rand(20); run_frame(20, 3, 2, 0, "R3 gap2");
    fill_rand(30); run_frame(30, 5, 5, 0, "R3 gap5");
    for (int i = 1; i <= 30; i++) rb[i] = 1;
    run_frame(30, 1, 3, 0, "R3 ones gap3");
  endtask

  task automatic t_s0();
    fill_rand(16); run_frame(16, 4, 0, 0, "R4 gap0");
    for (int i = 6; i <= 16; i++) chk($sformatf("R4 tap p%0d", i), got[i], got[i-1] ^ got[i-5] ^ rb[i]);
  endtask

  task automatic t_frames();
    for (int i = 1; i <= 9; i++) rb[i] = 1;
    run_frame(9, 2, 1, 0, "R5 frame A");
    fill_rand(9);
    run_frame(9, 2, 1, 0, "R5 frame B");
    run_frame(9, 2, 1, 0, "R5 frame B repeat");
  endtask

  task automatic t_stall();
    fill_rand(10); run_frame(10, 2, 1, 3, "R7 stall mid");
    fill_rand(10); run_frame(10, 2, 1, 10, "R7 stall last");
  endtask

  task automatic t_bad();
    len = 11'd7; lag = 6'd6; gap = 4'd1;
    in_valid = 1'b1; in_bit = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R8 cfg_bad high", int'(bad), 1);
      chk("R8 in_ready low", int'(in_ready), 0);
      chk("R8 no output", int'(out_valid), 0);
    end
    in_valid = 1'b0;
    fill_rand(7); run_frame(7, 2, 1, 0, "R8 after bad");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    in_valid = 1'b0; in_bit = 1'b0; out_ready = 1'b1;
    len = 11'd7; lag = 6'd2; gap = 4'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_vector();
    t_prezone();
    t_gaps();
    t_s0();
    t_frames();
    t_stall();
    t_bad();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule